// File: doc/BRIEF.md
# ADC Limit Monitor with Threshold Interrupt

This block watches a stream of 8-bit conversion results from up to three multiplexed analog channels. Each accepted sample is stored as the channel's most recent value and compared at once against that channel's own upper and lower limit. A limit hit raises a sticky per-channel flag. Two shared enable bits, one for upper hits and one for lower hits, decide whether any raised flag pulls the active-low interrupt line.

A host reaches the block through a small synchronous register port. The port has a write strobe, an address and write data, plus a combinational read bus. Through it the host sets the limits, picks the active channels, enables the interrupt directions and clears flags by writing ones. A host that wants a single fresh reading writes the channel number to a command address. The block then pulses a conversion request toward the converter and clears its data-ready bit. When the matching result has been captured, the block sets data-ready again.

Samples arrive with a valid strobe and a channel index. Index 1 to 3 selects a channel. Index 0, and any sample for a channel that is switched off, is dropped.

Top module: `adc_limit_monitor`

## Requirements
- R1: After reset, every register reads 0x00, `irqN` is 1 and `convReq` is 0. The register map is: control 0x0, status 0x1, command 0x2, latest data of channel k at 0x3+k, upper limit of channel k at 0x7+k, and lower limit of channel k at 0xB+k, for k = 1..3. The limit registers are read/write.
- R2: A captured sample that is greater than or equal to its channel's upper limit sets that channel's upper flag on the same clock edge.
- R3: A captured sample that is less than or equal to its channel's lower limit sets that channel's lower flag on the same clock edge.
- R4: Control bit 6 is a spare channel-select bit, bits 5, 4 and 3 select channels 1, 2 and 3, bit 2 enables lower-flag interrupts and bit 1 enables upper-flag interrupts. Bits 7 and 0 always read 0.
- R5: A sample for a channel whose select bit is 0 is dropped: its data register reads 0x00, it stays 0x00 after the channel is later selected, and no flag is raised.
- R6: `irqN` is driven low one clock after any upper flag is set while the upper enable is 1, or any lower flag is set while the lower enable is 1. It returns high one clock after no enabled flag remains.
- R7: Flags are sticky and are cleared only by writing 1 to their status bit. Clearing an enable masks the interrupt but keeps the flag. A set and a clear of the same flag in the same cycle leaves the flag set.
- R8: A channel's data register holds its latest captured sample and can be read in the cycle after the capture edge.
- R9: A write to the command address pulses `convReq` for one cycle, puts write-data bits 1:0 on `convCh` and clears data-ready. Data-ready sets one clock after a sample for that channel is captured. Samples for other channels leave it clear.
- R10: In the status register, bits 2:0 are the upper flags of channels 1..3, bits 5:3 are the lower flags of channels 1..3, bit 7 is data-ready and bit 6 reads 0. Writing 1 to bits 5:0 clears the matching flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address (read and write) |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Combinational read data for `addr` |
| sampleValid | input | 1 | Conversion result strobe |
| sampleCh | input | 2 | Channel index of the result (1..3) |
| sampleData | input | 8 | Conversion result |
| convReq | output | 1 | One-cycle on-demand conversion request |
| convCh | output | 2 | Channel of the latest request |
| irqN | output | 1 | Registered active-low interrupt |

## Verification
A sample strobed before edge N shows up in the data register and the flags at the negative edge right after N. The interrupt line follows one edge later, at N+1. A command write shows `convReq` and the cleared data-ready right after its edge. Data-ready returns one edge after the matching capture. Every task drives its inputs on a falling edge and samples on the following falling edges. At each step it checks that a lagging output still holds its old value, and then checks the new value one cycle later. This exposes an extra or a missing register stage.

// File: rtl/adc_limit_pkg.sv
`timescale 1ns/1ps
package adc_limit_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 4;
  localparam int CH_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h1;
  localparam logic [ADDR_W-1:0] A_CMD  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DATA = 4'h4;  // channel k (0-based) at A_DATA+k
  localparam logic [ADDR_W-1:0] A_HIGH = 4'h8;
  localparam logic [ADDR_W-1:0] A_LOW  = 4'hC;

  localparam int B_ALIE = 2;
  localparam int B_AHIE = 1;
  localparam int B_CS1  = 5;  // channel k (0-based) select at B_CS1-k

  typedef struct packed {
    logic              wrCtrl;
    logic              wrStatus;
    logic              conv;
    logic [NUM_CH-1:0] wrHigh;
    logic [NUM_CH-1:0] wrLow;
    logic [NUM_CH-1:0] take;
  } strobe_t;
endpackage

// File: rtl/adc_limit_ctrl.sv
`timescale 1ns/1ps
module adc_limit_ctrl
  import adc_limit_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sampleValid,
  input  logic [CH_W-1:0]   sampleCh,
  input  logic [NUM_CH-1:0] csMask,
  output strobe_t           stb
);
  always_comb begin
    stb          = '0;
    stb.wrCtrl   = wrEn && (addr == A_CTRL);
    stb.wrStatus = wrEn && (addr == A_STAT);
    stb.conv     = wrEn && (addr == A_CMD);
    for (int k = 0; k < NUM_CH; k++) begin
      stb.wrHigh[k] = wrEn && (addr == (A_HIGH + ADDR_W'(k)));
      stb.wrLow[k]  = wrEn && (addr == (A_LOW + ADDR_W'(k)));
      stb.take[k]   = sampleValid && (sampleCh == CH_W'(k + 1)) && csMask[k];
    end
  end
endmodule

// File: rtl/adc_limit_datapath.sv
`timescale 1ns/1ps
module adc_limit_datapath
  import adc_limit_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        sampleData,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH-1:0]        csMask,
  output logic [DATA_W-1:0]        ctrlReg,
  output logic [NUM_CH-1:0]        hiFlag,
  output logic [NUM_CH-1:0]        loFlag,
  output logic                     dataReady,
  output logic [NUM_CH*DATA_W-1:0] hiThrFlat,
  output logic [NUM_CH*DATA_W-1:0] loThrFlat,
  output logic                     convReq,
  output logic [CH_W-1:0]          convCh,
  output logic                     irqN
);
  logic [DATA_W-3:0] ctrlBits;
  logic [DATA_W-1:0] curData [NUM_CH];
  logic [DATA_W-1:0] hiThr   [NUM_CH];
  logic [DATA_W-1:0] loThr   [NUM_CH];
  logic              pendActive, drArm, matchTake;
  logic [NUM_CH-1:0] pendHit;

  assign ctrlReg = {1'b0, ctrlBits, 1'b0};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           ctrlBits <= '0;
    else if (stb.wrCtrl) ctrlBits <= wrData[DATA_W-2:1];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hiSet, loSet, hiClr, loClr;
    assign csMask[k] = ctrlReg[B_CS1-k];
    assign hiSet = stb.take[k] && (sampleData >= hiThr[k]);
    assign loSet = stb.take[k] && (sampleData <= loThr[k]);
    assign hiClr = stb.wrStatus && wrData[k];
    assign loClr = stb.wrStatus && wrData[NUM_CH+k];
    assign hiThrFlat[k*DATA_W +: DATA_W] = hiThr[k];
    assign loThrFlat[k*DATA_W +: DATA_W] = loThr[k];
    assign pendHit[k] = stb.take[k] && (convCh == CH_W'(k + 1));

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        curData[k] <= '0;
        hiThr[k]   <= '0;
        loThr[k]   <= '0;
        hiFlag[k]  <= 1'b0;
        loFlag[k]  <= 1'b0;
      end else begin
        if (stb.take[k])   curData[k] <= sampleData;
        if (stb.wrHigh[k]) hiThr[k]   <= wrData;
        if (stb.wrLow[k])  loThr[k]   <= wrData;
        hiFlag[k] <= hiSet | (hiFlag[k] & ~hiClr);
        loFlag[k] <= loSet | (loFlag[k] & ~loClr);
      end
  end

  assign matchTake = pendActive && (|pendHit);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      convReq    <= 1'b0;
      convCh     <= '0;
      pendActive <= 1'b0;
      drArm      <= 1'b0;
      dataReady  <= 1'b0;
    end else begin
      convReq <= stb.conv;
      if (stb.conv) begin
        convCh     <= wrData[CH_W-1:0];
        pendActive <= 1'b1;
        drArm      <= 1'b0;
        dataReady  <= 1'b0;
      end else begin
        drArm <= matchTake;
        if (matchTake) pendActive <= 1'b0;
        if (drArm)     dataReady  <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) irqN <= 1'b1;
    else irqN <= !((ctrlReg[B_ALIE] && (|loFlag)) || (ctrlReg[B_AHIE] && (|hiFlag)));

  always_comb begin
    rdData = '0;
    if (addr == A_CTRL) rdData = ctrlReg;
    if (addr == A_STAT) begin
      rdData[NUM_CH-1:0]        = hiFlag;
      rdData[2*NUM_CH-1:NUM_CH] = loFlag;
      rdData[DATA_W-1]          = dataReady;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr == (A_DATA + ADDR_W'(k))) rdData = csMask[k] ? curData[k] : '0;
      if (addr == (A_HIGH + ADDR_W'(k))) rdData = hiThr[k];
      if (addr == (A_LOW + ADDR_W'(k)))  rdData = loThr[k];
    end
  end
endmodule

// File: rtl/adc_limit_monitor.sv
`timescale 1ns/1ps
module adc_limit_monitor
  import adc_limit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sampleValid,
  input  logic [CH_W-1:0]   sampleCh,
  input  logic [DATA_W-1:0] sampleData,
  output logic              convReq,
  output logic [CH_W-1:0]   convCh,
  output logic              irqN
);
  strobe_t                  stb;
  logic [NUM_CH-1:0]        csMask, hiFlag, loFlag;
  logic [DATA_W-1:0]        ctrlReg;
  logic                     dataReady;
  logic [NUM_CH*DATA_W-1:0] hiThrFlat, loThrFlat;

  adc_limit_ctrl u_ctrl (
    .wrEn(wrEn), .addr(addr), .sampleValid(sampleValid),
    .sampleCh(sampleCh), .csMask(csMask), .stb(stb)
  );

  adc_limit_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .sampleData(sampleData), .rdData(rdData), .csMask(csMask),
    .ctrlReg(ctrlReg), .hiFlag(hiFlag), .loFlag(loFlag),
    .dataReady(dataReady), .hiThrFlat(hiThrFlat), .loThrFlat(loThrFlat),
    .convReq(convReq), .convCh(convCh), .irqN(irqN)
  );
endmodule

// File: rtl/adc_limit_monitor_chk.sv
`timescale 1ns/1ps
module adc_limit_monitor_chk
  import adc_limit_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wrData,
  input logic                     sampleValid,
  input logic [CH_W-1:0]          sampleCh,
  input logic [DATA_W-1:0]        sampleData,
  input logic                     convReq,
  input logic                     irqN,
  input logic [DATA_W-1:0]        ctrlReg,
  input logic [NUM_CH-1:0]        hiFlag,
  input logic [NUM_CH-1:0]        loFlag,
  input logic                     dataReady,
  input logic [NUM_CH*DATA_W-1:0] hiThrFlat,
  input logic [NUM_CH*DATA_W-1:0] loThrFlat
);
  logic stWr;
  assign stWr = wrEn && (addr == A_STAT);

  // R6: a low interrupt needs an enabled flag one cycle earlier
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> $past((ctrlReg[B_AHIE] && (|hiFlag)) || (ctrlReg[B_ALIE] && (|loFlag))));

  // R9: a conversion request always comes with data-ready cleared
  p_dr_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> !dataReady);

  // R7: no flag drops without a write-one-to-clear
  p_hi_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    &(~$past(hiFlag) | hiFlag | ($past(stWr) ? $past(wrData[NUM_CH-1:0]) : '0)));
  p_lo_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    &(~$past(loFlag) | loFlag | ($past(stWr) ? $past(wrData[2*NUM_CH-1:NUM_CH]) : '0)));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    logic hit;
    assign hit = sampleValid && (sampleCh == CH_W'(k + 1));
    p_high_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      (hit && ctrlReg[B_CS1-k] && (sampleData >= hiThrFlat[k*DATA_W +: DATA_W])) |=> hiFlag[k]);
    p_low_set_r3: assert property (@(posedge clk) disable iff (!rstN)
      (hit && ctrlReg[B_CS1-k] && (sampleData <= loThrFlat[k*DATA_W +: DATA_W])) |=> loFlag[k]);
    p_skip_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hit && !ctrlReg[B_CS1-k] && !hiFlag[k] && !loFlag[k]) |=> (!hiFlag[k] && !loFlag[k]));
  end
endmodule

bind adc_limit_monitor adc_limit_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .sampleValid(sampleValid), .sampleCh(sampleCh), .sampleData(sampleData),
  .convReq(convReq), .irqN(irqN), .ctrlReg(ctrlReg), .hiFlag(hiFlag),
  .loFlag(loFlag), .dataReady(dataReady), .hiThrFlat(hiThrFlat),
  .loThrFlat(loThrFlat)
);

// File: tb/sim_adc_limit_monitor.sv
`timescale 1ns/1ps
module sim_adc_limit_monitor;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       wrEn = 1'b0, sampleValid = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0, sampleData = '0, rdData;
  logic [1:0] sampleCh = '0, convCh;
  logic       convReq, irqN;
  int         nCmp = 0, nBad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  adc_limit_monitor u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sampleValid(sampleValid), .sampleCh(sampleCh),
    .sampleData(sampleData), .convReq(convReq), .convCh(convCh), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a; #0.5; check(req, rdData, exp);
  endtask

  task automatic samp(input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk); sampleValid = 1'b1; sampleCh = ch; sampleData = d;
    @(negedge clk); sampleValid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irqN", {7'd0, irqN}, 8'h01);
    check("R1 convReq", {7'd0, convReq}, 8'h00);
    rdChk("R1 ctrl", 4'h0, 8'h00);
    rdChk("R1 status", 4'h1, 8'h00);
    rdChk("R1 high3", 4'hA, 8'h00);
    rdChk("R1 low1", 4'hC, 8'h00);
  endtask

  task automatic t_layout();
    wr(4'h0, 8'hFF);
    rdChk("R4 pad bits", 4'h0, 8'h7E);
    wr(4'h0, 8'h00);
    wr(4'h8, 8'h80); wr(4'h9, 8'hFF); wr(4'hA, 8'h10);
    wr(4'hD, 8'h20); wr(4'hE, 8'h10);
    rdChk("R1 high1 rw", 4'h8, 8'h80);
    rdChk("R1 low2 rw", 4'hD, 8'h20);
  endtask

  task automatic t_disabled();
    wr(4'h0, 8'h10);             // only channel 2 selected
    samp(2'd1, 8'h90);
    rdChk("R5 data1 off", 4'h4, 8'h00);
    rdChk("R5 no flag", 4'h1, 8'h00);
    wr(4'h0, 8'h3A);             // all channels, upper enable
    rdChk("R5 dropped sample", 4'h4, 8'h00);
  endtask

  task automatic t_high();
    samp(2'd1, 8'h7F);
    rdChk("R2 below limit", 4'h1, 8'h00);
    rdChk("R8 data1", 4'h4, 8'h7F);
    samp(2'd1, 8'h80);
    rdChk("R2 equal limit", 4'h1, 8'h01);
    rdChk("R8 data1 new", 4'h4, 8'h80);
    check("R6 irq lag", {7'd0, irqN}, 8'h01);
    @(negedge clk);
    check("R6 irq low", {7'd0, irqN}, 8'h00);
    wr(4'h1, 8'h01);
    rdChk("R10 clear high1", 4'h1, 8'h00);
    @(negedge clk);
    check("R6 irq release", {7'd0, irqN}, 8'h01);
  endtask

  task automatic t_low();
    samp(2'd2, 8'h21);
    rdChk("R3 above limit", 4'h1, 8'h00);
    samp(2'd2, 8'h20);
    rdChk("R3 equal limit", 4'h1, 8'h10);
    @(negedge clk);
    check("R7 lower masked", {7'd0, irqN}, 8'h01);
    wr(4'h0, 8'h3E);
    @(negedge clk);
    check("R6 lower enabled", {7'd0, irqN}, 8'h00);
    wr(4'h0, 8'h3A);
    @(negedge clk);
    check("R7 mask again", {7'd0, irqN}, 8'h01);
    rdChk("R7 flag kept", 4'h1, 8'h10);
    wr(4'h1, 8'h10);
    rdChk("R10 clear low2", 4'h1, 8'h00);
  endtask

  task automatic t_both();
    samp(2'd3, 8'h10);
    rdChk("R10 both ch3", 4'h1, 8'h24);
    wr(4'h1, 8'h24);
    rdChk("R7 w1c", 4'h1, 8'h00);
  endtask

  task automatic t_setwins();
    @(negedge clk);
    sampleValid = 1'b1; sampleCh = 2'd1; sampleData = 8'h90;
    wrEn = 1'b1; addr = 4'h1; wrData = 8'h01;
    @(negedge clk);
    sampleValid = 1'b0; wrEn = 1'b0;
    rdChk("R7 set beats clear", 4'h1, 8'h01);
    wr(4'h1, 8'h01);
  endtask

  task automatic t_ready();
    wr(4'h2, 8'h03);
    check("R9 convReq", {7'd0, convReq}, 8'h01);
    check("R9 convCh", {6'd0, convCh}, 8'h03);
    rdChk("R9 ready clear", 4'h1, 8'h00);
    @(negedge clk);
    check("R9 pulse ends", {7'd0, convReq}, 8'h00);
    samp(2'd2, 8'h60);
    @(negedge clk);
    rdChk("R9 other channel", 4'h1, 8'h00);
    samp(2'd3, 8'h40);
    addr = 4'h1; #0.5; check("R9 ready lag", {7'd0, rdData[7]}, 8'h00);
    @(negedge clk);
    addr = 4'h1; #0.5; check("R9 ready set", {7'd0, rdData[7]}, 8'h01);
    rdChk("R8 data3", 4'h6, 8'h40);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_disabled();
    t_high();
    t_low();
    t_both();
    t_setwins();
    t_ready();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule